// File: doc/BRIEF.md
# Bus Transfer Type Selector and Sequencer

This block sits between a data cache's miss handling and the external memory bus. For each memory access it decides whether the access goes out as one single-beat transfer or as a four-beat burst that fills a whole cache line. It then presents the request, holds it until the bus acknowledges it, and steps through the data beats as the bus signals each one ready.

The decision uses the access's page attribute bits, a write-through flag, and the cache-enable and cache-lock controls. A caching-inhibited access, a write-through store, or any access made while the cache is off or locked goes out as a single beat. A single beat carries 1 to 8 bytes and keeps the caller's address unchanged, so it may be misaligned. Every other access is a line fill: 32 bytes in four 8-byte beats, starting at the line-aligned address. While a transfer is in flight the block reports busy and ignores new accesses.

Top module: `bus_xfer_seq`

## Requirements
- R1: During and right after reset, `acc_busy`, `bus_req`, `beat_strb` and `beat_last` are all 0.
- R2: An access whose caching-inhibited attribute bit `acc_wimg[2]` is 1 is issued as a single beat (`bus_burst` = 0).
- R3: A store (`acc_write` = 1) that is write-through, meaning `acc_wt` = 1 or the write-through attribute bit `acc_wimg[3]` = 1, is issued as a single beat. A load with the same attributes is not affected by this rule.
- R4: Any access made while `dc_enable` = 0 is issued as a single beat.
- R5: Any access made while `dc_lock` = 1 is issued as a single beat.
- R6: Every access that none of R2 to R5 covers is a burst: `bus_burst` = 1, `bus_beats` = 4, `bus_bytes` = 32, and `bus_addr` is the access address with its low 5 bits cleared.
- R7: A single beat has `bus_beats` = 1 and `bus_addr` equal to the unmodified access address. `bus_bytes` equals `acc_size` when that is 1 to 8, and is 8 when `acc_size` is 0 or above 8.
- R8: An access accepted at a clock edge (`acc_valid` = 1 while idle) shows `acc_busy` = 1 and `bus_req` = 1 after that edge. `bus_req` stays high until the edge at which `bus_ack` is sampled high, and falls after that edge.
- R9: After acknowledge, `beat_strb` is one-hot on the index of the beat now expected, starting at bit 0. It advances only at an edge where `bus_rdy` = 1. `beat_last` is 1 only on the final beat. `bus_rdy` before acknowledge has no effect, and `beat_strb` is 0 outside the data phase.
- R10: While busy, `acc_valid` is ignored and the request fields stay stable. The block becomes idle after the edge at which the final beat's `bus_rdy` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access byte address |
| acc_size | input | 4 | Access size in bytes (1 to 8) |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_wimg | input | 4 | Page attributes: bit 3 write-through, bit 2 caching-inhibited, bits 1:0 unused here |
| acc_wt | input | 1 | Write-through status of the access |
| dc_enable | input | 1 | Data cache enabled |
| dc_lock | input | 1 | Data cache locked |
| acc_busy | output | 1 | Transfer in flight; new accesses ignored |
| bus_req | output | 1 | Bus request, held until acknowledged |
| bus_burst | output | 1 | Transfer type: 1 burst, 0 single beat |
| bus_addr | output | 32 | Transfer start address |
| bus_bytes | output | 6 | Byte count of the transfer |
| bus_beats | output | 3 | Beat count of the transfer |
| bus_ack | input | 1 | Bus accepts the request |
| bus_rdy | input | 1 | Current data beat completes |
| beat_strb | output | 4 | One-hot index of the expected beat |
| beat_last | output | 1 | Expected beat is the final one |

## Verification
The request fields and `bus_req` are due one edge after the accepting edge. `bus_req` falls one edge after the edge that samples `bus_ack`. Each strobe advance, and the return to idle, is due one edge after a sampled `bus_rdy`. The bench drives every input on the falling clock edge and samples each output on the following falling edge, so exactly one rising edge separates stimulus from observation. In the waits before acknowledge and in the gap cycles it checks that nothing moved. It sweeps all 256 combinations of attribute bits, direction, write-through, enable and lock, and also every size code against every byte offset within a doubleword.

// File: rtl/bxs_pkg.sv
package bxs_pkg;
    // attribute bit positions inside the 4-bit page attribute field
    localparam int ATTR_WT_BIT = 3;
    localparam int ATTR_CI_BIT = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_DATA = 2'd2
    } seq_state_e;
endpackage

// File: rtl/bxs_classify.sv
module bxs_classify #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int BEAT_BYTES = 8
) (
    input  logic [ADDR_W-1:0]                     acc_addr,
    input  logic [$clog2(BEAT_BYTES+1)-1:0]       acc_size,
    input  logic                                  acc_write,
    input  logic [3:0]                            acc_wimg,
    input  logic                                  acc_wt,
    input  logic                                  dc_enable,
    input  logic                                  dc_lock,
    output logic                                  burst,
    output logic [ADDR_W-1:0]                     xfer_addr,
    output logic [$clog2(LINE_BYTES+1)-1:0]       xfer_bytes,
    output logic [$clog2(LINE_BYTES/BEAT_BYTES+1)-1:0] xfer_beats
);
    import bxs_pkg::*;

    localparam int SIZE_W      = $clog2(BEAT_BYTES+1);
    localparam int BYTES_W     = $clog2(LINE_BYTES+1);
    localparam int BURST_BEATS = LINE_BYTES / BEAT_BYTES;
    localparam int BEAT_CW     = $clog2(BURST_BEATS+1);
    localparam int OFFS_W      = $clog2(LINE_BYTES);

    localparam logic [BYTES_W-1:0] LINE_CNT  = BYTES_W'(LINE_BYTES);
    localparam logic [BYTES_W-1:0] BEAT_CNT  = BYTES_W'(BEAT_BYTES);
    localparam logic [SIZE_W-1:0]  SIZE_MAX  = SIZE_W'(BEAT_BYTES);
    localparam logic [BEAT_CW-1:0] BURST_CNT = BEAT_CW'(BURST_BEATS);

    logic inhibited;
    logic wt_store;
    logic force_single;
    logic size_ok;

    always_comb begin
        inhibited    = acc_wimg[ATTR_CI_BIT];
        wt_store     = acc_write & (acc_wt | acc_wimg[ATTR_WT_BIT]);
        force_single = inhibited | wt_store | ~dc_enable | dc_lock;
        burst        = ~force_single;

        size_ok = (acc_size != '0) && (acc_size <= SIZE_MAX);

        if (burst) begin
            xfer_addr  = {acc_addr[ADDR_W-1:OFFS_W], {OFFS_W{1'b0}}};
            xfer_bytes = LINE_CNT;
            xfer_beats = BURST_CNT;
        end else begin
            xfer_addr  = acc_addr;
            xfer_bytes = size_ok ? BYTES_W'(acc_size) : BEAT_CNT;
            xfer_beats = BEAT_CW'(1);
        end
    end
endmodule

// File: rtl/bxs_strobe.sv
module bxs_strobe #(
    parameter int N_BEATS = 4
) (
    input  logic                       active,
    input  logic [$clog2(N_BEATS)-1:0] idx,
    output logic [N_BEATS-1:0]         strb
);
    for (genvar g = 0; g < N_BEATS; g++) begin : g_lane
        assign strb[g] = active && (idx == ($clog2(N_BEATS))'(g));
    end
endmodule

// File: rtl/bus_xfer_seq.sv
module bus_xfer_seq #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int BEAT_BYTES = 8
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       acc_valid,
    input  logic [ADDR_W-1:0]                          acc_addr,
    input  logic [$clog2(BEAT_BYTES+1)-1:0]            acc_size,
    input  logic                                       acc_write,
    input  logic [3:0]                                 acc_wimg,
    input  logic                                       acc_wt,
    input  logic                                       dc_enable,
    input  logic                                       dc_lock,
    output logic                                       acc_busy,
    output logic                                       bus_req,
    output logic                                       bus_burst,
    output logic [ADDR_W-1:0]                          bus_addr,
    output logic [$clog2(LINE_BYTES+1)-1:0]            bus_bytes,
    output logic [$clog2(LINE_BYTES/BEAT_BYTES+1)-1:0] bus_beats,
    input  logic                                       bus_ack,
    input  logic                                       bus_rdy,
    output logic [LINE_BYTES/BEAT_BYTES-1:0]           beat_strb,
    output logic                                       beat_last
);
    import bxs_pkg::*;

    localparam int BYTES_W     = $clog2(LINE_BYTES+1);
    localparam int BURST_BEATS = LINE_BYTES / BEAT_BYTES;
    localparam int BEAT_CW     = $clog2(BURST_BEATS+1);
    localparam int IDX_W       = $clog2(BURST_BEATS);

    typedef struct packed {
        seq_state_e         state;
        logic               burst;
        logic [ADDR_W-1:0]  addr;
        logic [BYTES_W-1:0] bytes;
        logic [BEAT_CW-1:0] beats;
        logic [IDX_W-1:0]   idx;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic               cls_burst;
    logic [ADDR_W-1:0]  cls_addr;
    logic [BYTES_W-1:0] cls_bytes;
    logic [BEAT_CW-1:0] cls_beats;
    logic               in_data;
    logic               on_last;

    bxs_classify #(
        .ADDR_W    (ADDR_W),
        .LINE_BYTES(LINE_BYTES),
        .BEAT_BYTES(BEAT_BYTES)
    ) u_classify (
        .acc_addr  (acc_addr),
        .acc_size  (acc_size),
        .acc_write (acc_write),
        .acc_wimg  (acc_wimg),
        .acc_wt    (acc_wt),
        .dc_enable (dc_enable),
        .dc_lock   (dc_lock),
        .burst     (cls_burst),
        .xfer_addr (cls_addr),
        .xfer_bytes(cls_bytes),
        .xfer_beats(cls_beats)
    );

    bxs_strobe #(
        .N_BEATS(BURST_BEATS)
    ) u_strobe (
        .active(in_data),
        .idx   (r_q.idx),
        .strb  (beat_strb)
    );

    always_comb begin
        in_data = (r_q.state == ST_DATA);
        on_last = in_data && (BEAT_CW'(r_q.idx) == (r_q.beats - BEAT_CW'(1)));

        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (acc_valid) begin
                    r_d.state = ST_REQ;
                    r_d.burst = cls_burst;
                    r_d.addr  = cls_addr;
                    r_d.bytes = cls_bytes;
                    r_d.beats = cls_beats;
                    r_d.idx   = '0;
                end
            end
            ST_REQ: begin
                if (bus_ack) begin
                    r_d.state = ST_DATA;
                end
            end
            ST_DATA: begin
                if (bus_rdy) begin
                    if (on_last) begin
                        r_d.state = ST_IDLE;
                        r_d.idx   = '0;
                    end else begin
                        r_d.idx = r_q.idx + IDX_W'(1);
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, burst: 1'b0, addr: '0,
                     bytes: '0, beats: '0, idx: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign acc_busy  = (r_q.state != ST_IDLE);
    assign bus_req   = (r_q.state == ST_REQ);
    assign bus_burst = r_q.burst;
    assign bus_addr  = r_q.addr;
    assign bus_bytes = r_q.bytes;
    assign bus_beats = r_q.beats;
    assign beat_last = on_last;
endmodule

// File: rtl/bxs_chk.sv
module bxs_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int BEAT_BYTES = 8
) (
    input logic                                       clk,
    input logic                                       rst_n,
    input logic                                       acc_valid,
    input logic [3:0]                                 acc_wimg,
    input logic                                       acc_busy,
    input logic                                       bus_req,
    input logic                                       bus_burst,
    input logic [ADDR_W-1:0]                          bus_addr,
    input logic [$clog2(LINE_BYTES+1)-1:0]            bus_bytes,
    input logic [$clog2(LINE_BYTES/BEAT_BYTES+1)-1:0] bus_beats,
    input logic                                       bus_ack,
    input logic                                       bus_rdy,
    input logic [LINE_BYTES/BEAT_BYTES-1:0]           beat_strb,
    input logic                                       beat_last
);
    localparam int BURST_BEATS = LINE_BYTES / BEAT_BYTES;
    localparam int OFFS_W      = $clog2(LINE_BYTES);

    // R2
    ci_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_busy && acc_wimg[2] |=> bus_req && !bus_burst);

    // R6
    burst_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_burst |-> (int'(bus_beats) == BURST_BEATS)
            && (int'(bus_bytes) == LINE_BYTES)
            && (bus_addr[OFFS_W-1:0] == '0));

    // R7
    single_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_burst |-> (int'(bus_beats) == 1)
            && (bus_bytes != '0) && (int'(bus_bytes) <= BEAT_BYTES));

    // R8
    accept_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_busy |=> bus_req && acc_busy);

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req);

    // R9
    strb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(beat_strb) && (bus_req -> beat_strb == '0));

    // R9
    last_strb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> ($countones(beat_strb) == 1) && acc_busy);

    // R10
    busy_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_busy && !(beat_last && bus_rdy) |=> acc_busy
            && $stable(bus_addr) && $stable(bus_burst) && $stable(bus_bytes));

    // R10
    finish_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last && bus_rdy |=> !acc_busy);
endmodule

bind bus_xfer_seq bxs_chk #(
    .ADDR_W    (ADDR_W),
    .LINE_BYTES(LINE_BYTES),
    .BEAT_BYTES(BEAT_BYTES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_valid(acc_valid),
    .acc_wimg (acc_wimg),
    .acc_busy (acc_busy),
    .bus_req  (bus_req),
    .bus_burst(bus_burst),
    .bus_addr (bus_addr),
    .bus_bytes(bus_bytes),
    .bus_beats(bus_beats),
    .bus_ack  (bus_ack),
    .bus_rdy  (bus_rdy),
    .beat_strb(beat_strb),
    .beat_last(beat_last)
);

// File: tb/tb_bus_xfer_seq.sv
module tb_bus_xfer_seq;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_valid;
    logic [31:0] acc_addr;
    logic [3:0]  acc_size;
    logic        acc_write;
    logic [3:0]  acc_wimg;
    logic        acc_wt;
    logic        dc_enable;
    logic        dc_lock;
    logic        acc_busy;
    logic        bus_req;
    logic        bus_burst;
    logic [31:0] bus_addr;
    logic [5:0]  bus_bytes;
    logic [2:0]  bus_beats;
    logic        bus_ack;
    logic        bus_rdy;
    logic [3:0]  beat_strb;
    logic        beat_last;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    bus_xfer_seq dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_write(acc_write), .acc_wimg(acc_wimg),
        .acc_wt(acc_wt), .dc_enable(dc_enable), .dc_lock(dc_lock),
        .acc_busy(acc_busy), .bus_req(bus_req), .bus_burst(bus_burst),
        .bus_addr(bus_addr), .bus_bytes(bus_bytes), .bus_beats(bus_beats),
        .bus_ack(bus_ack), .bus_rdy(bus_rdy), .beat_strb(beat_strb),
        .beat_last(beat_last)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic xfer(input logic [31:0] a, input logic [3:0] sz, input bit wr,
                        input logic [3:0] wimg, input bit wt, input bit en, input bit lk,
                        input int ack_wait, input bit gaps, input bit spam);
        bit          e_burst;
        int          e_beats;
        int          e_bytes;
        logic [31:0] e_addr;
        string       tag;
        e_burst = !wimg[2] && !(wr && (wt || wimg[3])) && en && !lk;
        if (wimg[2])                 tag = "R2";
        else if (wr && (wt || wimg[3])) tag = "R3";
        else if (!en)                tag = "R4";
        else if (lk)                 tag = "R5";
        else                         tag = "R6";
        e_beats = e_burst ? 4 : 1;
        e_bytes = e_burst ? 32 : ((sz == 0 || sz > 8) ? 8 : int'(sz));
        e_addr  = e_burst ? (a & ~32'h1F) : a;

        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_size = sz; acc_write = wr;
        acc_wimg = wimg; acc_wt = wt; dc_enable = en; dc_lock = lk;
        bus_ack = 1'b0; bus_rdy = 1'b0;
        @(negedge clk);
        acc_valid = spam;
        if (spam) begin
            acc_addr = ~a; acc_wimg = 4'b0000; acc_write = 1'b0;
            dc_enable = 1'b1; dc_lock = 1'b0; acc_size = 4'd3;
        end
        chk(acc_busy && bus_req, "R8", "busy/req after accept", {acc_busy, bus_req}, 2'b11);
        chk(bus_burst == e_burst, tag, "transfer type", bus_burst, e_burst);
        chk(int'(bus_beats) == e_beats, e_burst ? "R6" : "R7", "beats", bus_beats, e_beats);
        chk(int'(bus_bytes) == e_bytes, e_burst ? "R6" : "R7", "bytes", bus_bytes, e_bytes);
        chk(bus_addr == e_addr, e_burst ? "R6" : "R7", "address", bus_addr, e_addr);

        for (int i = 0; i < ack_wait; i++) begin
            bus_rdy = 1'b1;
            @(negedge clk);
            chk(bus_req == 1'b1, "R8", "req held before ack", bus_req, 1);
            chk(beat_strb == 4'b0, "R9", "no strobe before ack", beat_strb, 0);
        end
        bus_rdy = 1'b0; bus_ack = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0; acc_valid = 1'b0;
        chk(!bus_req && acc_busy, "R8", "req drops after ack", {bus_req, acc_busy}, 2'b01);
        chk(bus_addr == e_addr && bus_burst == e_burst, "R10",
            "fields stable while busy", bus_addr, e_addr);

        for (int b = 0; b < e_beats; b++) begin
            if (gaps) begin
                @(negedge clk);
                chk(beat_strb == 4'(1 << b), "R9", "strobe holds without rdy",
                    beat_strb, 1 << b);
            end
            chk(beat_strb == 4'(1 << b), "R9", "strobe index", beat_strb, 1 << b);
            chk(beat_last == (b == e_beats - 1), "R9", "last flag", beat_last,
                (b == e_beats - 1));
            bus_rdy = 1'b1;
            @(negedge clk);
            bus_rdy = 1'b0;
        end
        chk(!acc_busy && !bus_req && beat_strb == 4'b0, "R10", "idle after final beat",
            {acc_busy, bus_req, beat_strb}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; acc_valid = 1'b0; acc_addr = '0; acc_size = 4'd1;
        acc_write = 1'b0; acc_wimg = '0; acc_wt = 1'b0; dc_enable = 1'b1;
        dc_lock = 1'b0; bus_ack = 1'b0; bus_rdy = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state, with accesses offered during reset
        acc_valid = 1'b1;
        @(negedge clk);
        chk(!acc_busy && !bus_req && beat_strb == 0 && !beat_last, "R1", "reset outputs",
            {acc_busy, bus_req, beat_strb, beat_last}, 0);
        acc_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(!acc_busy && !bus_req && beat_strb == 0 && !beat_last, "R1", "after reset",
            {acc_busy, bus_req, beat_strb, beat_last}, 0);

        // R2..R6 decision sweep over attributes, direction, write-through, enable, lock
        for (int c = 0; c < 256; c++) begin
            logic [7:0] cv;
            cv = 8'(c);
            xfer(32'h1000_0000 + 32'(c * 37), 4'((c % 8) + 1), cv[4], cv[3:0], cv[5],
                 cv[6], cv[7], c % 3, cv[0], cv[1]);
        end

        // R7: every size code against every offset, single beats via inhibit
        for (int sz = 0; sz < 16; sz++) begin
            for (int off = 0; off < 8; off++) begin
                xfer(32'h2000_0040 + 32'(off), 4'(sz), off[0], 4'b0100, 1'b0,
                     1'b1, 1'b0, 0, 1'b0, 1'b0);
            end
        end

        // R10: back-to-back accesses with acc_valid held through a burst
        xfer(32'h3000_0013, 4'd4, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b0, 2, 1'b1, 1'b1);
        xfer(32'h3000_0027, 4'd2, 1'b1, 4'b0000, 1'b1, 1'b1, 1'b0, 0, 1'b0, 1'b0);

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule